// File: doc/BRIEF.md
# Basic-Block Exit Steering Unit

This unit sits at the exit of one basic block in a handshake-driven dataflow circuit. A single condition token, produced elsewhere inside the block, decides which successor block receives every value the block hands on. An eager fork splits the condition into one private copy for each steering unit. There is one steering unit per live-out value and one more for the data-less control token. Each steering unit joins its value with its copy of the condition. It forwards the value to the taken-side output when the condition is 1 and to the not-taken-side output when it is 0.

Some successor sides have no consumer. For each steering unit, two parameter masks state which sides are unused. An unused side goes to an internal absorber that is always ready and drops what it receives. Tokens sent there are consumed at once, and the matching output port stays idle. Every channel, input or output, uses a valid/ready handshake. A transfer happens in the cycle where both valid and ready are high.

Top module: `bbexit_steer`

## Requirements
- R1: After synchronous reset, with no input valid, every output valid and every input ready is 0. A condition token that was partly distributed before the reset leaves no trace: the next token reaches every steering unit exactly once.
- R2: With condition value 1, each live-out token appears exactly once on its taken-side output (`tk_valid[i]`, `tk_data` bits i*DW upward), with its data unchanged. Its not-taken side carries nothing.
- R3: With condition value 0, each live-out token appears exactly once on its not-taken-side output (`nt_valid[i]`, `nt_data`), with its data unchanged. Its taken side carries nothing.
- R4: A steering unit never raises valid on both of its outputs in the same cycle.
- R5: A steering unit neither offers nor accepts anything until both its value token and its copy of the condition are present. It consumes the two in the same cycle.
- R6: The fork hands each unit its copy as soon as that unit can take it, independent of the other units. It never offers a unit a second copy of the same condition. It accepts the condition (`cond_ready`) in exactly the cycle in which the last outstanding unit takes its copy.
- R7: A side whose bit is set in `TK_SINK` or `NT_SINK` (bit i for live-out i, bit N_LIVE for the control token) never raises its output valid. A token routed to that side is still consumed, with no wait for the output's ready.
- R8: The control token (`ctl_valid`/`ctl_ready`) is steered by the same rule as the live-outs, onto `ctl_tk_*` for condition 1 or `ctl_nt_*` for condition 0, without data.
- R9: While a selected output is valid and not ready, the corresponding input stays not ready and the offered output holds its valid and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_valid | input | 1 | Condition token present |
| cond_value | input | 1 | Condition: 1 taken side, 0 not-taken side |
| cond_ready | output | 1 | Condition token accepted |
| lo_valid | input | N_LIVE | Live-out token present, one bit per value |
| lo_data | input | N_LIVE*DW | Live-out payloads, value i in bits i*DW upward |
| lo_ready | output | N_LIVE | Live-out token accepted |
| ctl_valid | input | 1 | Control token present |
| ctl_ready | output | 1 | Control token accepted |
| tk_valid | output | N_LIVE | Taken-side token offered, per value |
| tk_data | output | N_LIVE*DW | Taken-side payloads |
| tk_ready | input | N_LIVE | Taken-side consumer ready |
| nt_valid | output | N_LIVE | Not-taken-side token offered, per value |
| nt_data | output | N_LIVE*DW | Not-taken-side payloads |
| nt_ready | input | N_LIVE | Not-taken-side consumer ready |
| ctl_tk_valid | output | 1 | Control token on taken side |
| ctl_tk_ready | input | 1 | Taken-side control consumer ready |
| ctl_nt_valid | output | 1 | Control token on not-taken side |
| ctl_nt_ready | input | 1 | Not-taken-side control consumer ready |

## Verification
The bench sweeps both condition values. For each one it gives every consumer its own ready delay of 0, 1 or 2 cycles. This separates an eager fork from one that waits for all units together. A stalled unit must not hold back the others, and the condition must be accepted exactly when the slowest unit finishes. Each pattern is run with the condition arriving first and arriving late, and with one value arriving late. This shows that a unit waits for both of its inputs. In the default configuration one not-taken side and one control side go to absorbers, so routed-but-dropped tokens are tried next to delivered ones. A reset in the middle of a half-served condition checks that no stale served state remains.

// File: rtl/bbexit_pkg.sv
package bbexit_pkg;

    localparam int MAX_LIVE = 4;

    typedef enum logic {
        SIDE_NOT_TAKEN = 1'b0,
        SIDE_TAKEN     = 1'b1
    } side_e;

    typedef struct packed {
        logic  valid;
        side_e side;
    } steer_s;

    function automatic logic pick_ready(input side_e s, input logic rdy_tk, input logic rdy_nt);
        return (s == SIDE_TAKEN) ? rdy_tk : rdy_nt;
    endfunction

    function automatic side_e to_side(input logic bitval);
        return bitval ? SIDE_TAKEN : SIDE_NOT_TAKEN;
    endfunction

endpackage

// File: rtl/bbx_fork.sv
module bbx_fork
    import bbexit_pkg::*;
#(
    parameter int N_OUT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  steer_s           in_tok,
    output logic             in_ready,
    output logic [N_OUT-1:0] out_valid,
    output side_e            out_side,
    input  logic [N_OUT-1:0] out_ready
);

    logic [N_OUT-1:0] served;
    logic [N_OUT-1:0] taken;

    always_comb begin
        out_side  = in_tok.side;
        out_valid = {N_OUT{in_tok.valid}} & ~served;
        taken     = served | (out_valid & out_ready);
        in_ready  = in_tok.valid & (&taken);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            served <= '0;
        end else if (in_tok.valid && in_ready) begin
            served <= '0;
        end else if (in_tok.valid) begin
            served <= taken;
        end
    end

    assert_fork_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (in_tok.valid && in_ready) |=> (served == '0));

    for (genvar k = 0; k < N_OUT; k++) begin : g_once
        assert_fork_single_copy_R6: assert property (@(posedge clk) disable iff (rst)
            (out_valid[k] && out_ready[k] && !in_ready) |=> !out_valid[k]);
    end

endmodule

// File: rtl/bbx_branch.sv
module bbx_branch
    import bbexit_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          d_valid,
    input  logic [DW-1:0] d_data,
    output logic          d_ready,
    input  logic          c_valid,
    input  side_e         c_side,
    output logic          c_ready,
    output logic          tk_valid,
    output logic [DW-1:0] tk_data,
    input  logic          tk_ready,
    output logic          nt_valid,
    output logic [DW-1:0] nt_data,
    input  logic          nt_ready
);

    logic joined;
    logic sel_ready;

    always_comb begin
        joined    = d_valid & c_valid;
        sel_ready = pick_ready(c_side, tk_ready, nt_ready);
        tk_valid  = joined & (c_side == SIDE_TAKEN);
        nt_valid  = joined & (c_side == SIDE_NOT_TAKEN);
        tk_data   = d_data;
        nt_data   = d_data;
        d_ready   = c_valid & sel_ready;
        c_ready   = d_valid & sel_ready;
    end

    assert_one_side_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tk_valid, nt_valid}));

    assert_joint_consume_R5: assert property (@(posedge clk) disable iff (rst)
        (d_valid && d_ready) |-> (c_valid && c_ready));

    assert_tk_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (tk_valid && !tk_ready) |=> (tk_valid && $stable(tk_data)));

    assert_nt_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (nt_valid && !nt_ready) |=> (nt_valid && $stable(nt_data)));

endmodule

// File: rtl/bbx_sink.sv
module bbx_sink #(
    parameter int DW = 8
) (
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready
);

    logic unused_sink_bits;

    assign unused_sink_bits = ^{in_valid, in_data};
    assign in_ready         = 1'b1;

endmodule

// File: rtl/bbexit_steer.sv
module bbexit_steer
    import bbexit_pkg::*;
#(
    parameter int                N_LIVE  = 2,
    parameter int                DW      = 8,
    parameter logic [MAX_LIVE:0] TK_SINK = 5'b00100,
    parameter logic [MAX_LIVE:0] NT_SINK = 5'b00001
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cond_valid,
    input  logic                 cond_value,
    output logic                 cond_ready,
    input  logic [N_LIVE-1:0]    lo_valid,
    input  logic [N_LIVE*DW-1:0] lo_data,
    output logic [N_LIVE-1:0]    lo_ready,
    input  logic                 ctl_valid,
    output logic                 ctl_ready,
    output logic [N_LIVE-1:0]    tk_valid,
    output logic [N_LIVE*DW-1:0] tk_data,
    input  logic [N_LIVE-1:0]    tk_ready,
    output logic [N_LIVE-1:0]    nt_valid,
    output logic [N_LIVE*DW-1:0] nt_data,
    input  logic [N_LIVE-1:0]    nt_ready,
    output logic                 ctl_tk_valid,
    input  logic                 ctl_tk_ready,
    output logic                 ctl_nt_valid,
    input  logic                 ctl_nt_ready
);

    localparam int N_UNITS = N_LIVE + 1;
    localparam int CTL_IDX = N_LIVE;

    steer_s             cond_tok;
    logic [N_UNITS-1:0] cp_valid;
    logic [N_UNITS-1:0] cp_ready;
    side_e              cp_side;

    assign cond_tok.valid = cond_valid;
    assign cond_tok.side  = to_side(cond_value);

    bbx_fork #(.N_OUT(N_UNITS)) u_fork (
        .clk       (clk),
        .rst       (rst),
        .in_tok    (cond_tok),
        .in_ready  (cond_ready),
        .out_valid (cp_valid),
        .out_side  (cp_side),
        .out_ready (cp_ready)
    );

    for (genvar i = 0; i < N_LIVE; i++) begin : g_live
        logic          b_tk_valid, b_nt_valid, b_tk_ready, b_nt_ready;
        logic [DW-1:0] b_tk_data, b_nt_data;

        bbx_branch #(.DW(DW)) u_branch (
            .clk      (clk),
            .rst      (rst),
            .d_valid  (lo_valid[i]),
            .d_data   (lo_data[i*DW +: DW]),
            .d_ready  (lo_ready[i]),
            .c_valid  (cp_valid[i]),
            .c_side   (cp_side),
            .c_ready  (cp_ready[i]),
            .tk_valid (b_tk_valid),
            .tk_data  (b_tk_data),
            .tk_ready (b_tk_ready),
            .nt_valid (b_nt_valid),
            .nt_data  (b_nt_data),
            .nt_ready (b_nt_ready)
        );

        if (TK_SINK[i]) begin : g_tk_sink
            logic unused_tk_rdy;
            assign unused_tk_rdy = tk_ready[i];
            bbx_sink #(.DW(DW)) u_sink (
                .in_valid (b_tk_valid),
                .in_data  (b_tk_data),
                .in_ready (b_tk_ready)
            );
            assign tk_valid[i]            = 1'b0;
            assign tk_data[i*DW +: DW]    = '0;
        end else begin : g_tk_port
            assign tk_valid[i]            = b_tk_valid;
            assign tk_data[i*DW +: DW]    = b_tk_data;
            assign b_tk_ready             = tk_ready[i];
        end

        if (NT_SINK[i]) begin : g_nt_sink
            logic unused_nt_rdy;
            assign unused_nt_rdy = nt_ready[i];
            bbx_sink #(.DW(DW)) u_sink (
                .in_valid (b_nt_valid),
                .in_data  (b_nt_data),
                .in_ready (b_nt_ready)
            );
            assign nt_valid[i]            = 1'b0;
            assign nt_data[i*DW +: DW]    = '0;
        end else begin : g_nt_port
            assign nt_valid[i]            = b_nt_valid;
            assign nt_data[i*DW +: DW]    = b_nt_data;
            assign b_nt_ready             = nt_ready[i];
        end
    end

    logic c_tk_valid, c_nt_valid, c_tk_ready, c_nt_ready;
    logic unused_ctl_tk_data, unused_ctl_nt_data;

    bbx_branch #(.DW(1)) u_ctl_branch (
        .clk      (clk),
        .rst      (rst),
        .d_valid  (ctl_valid),
        .d_data   (1'b0),
        .d_ready  (ctl_ready),
        .c_valid  (cp_valid[CTL_IDX]),
        .c_side   (cp_side),
        .c_ready  (cp_ready[CTL_IDX]),
        .tk_valid (c_tk_valid),
        .tk_data  (unused_ctl_tk_data),
        .tk_ready (c_tk_ready),
        .nt_valid (c_nt_valid),
        .nt_data  (unused_ctl_nt_data),
        .nt_ready (c_nt_ready)
    );

    if (TK_SINK[CTL_IDX]) begin : g_ctl_tk_sink
        logic unused_ctl_tk_rdy;
        assign unused_ctl_tk_rdy = ctl_tk_ready;
        bbx_sink #(.DW(1)) u_sink (
            .in_valid (c_tk_valid),
            .in_data  (1'b0),
            .in_ready (c_tk_ready)
        );
        assign ctl_tk_valid = 1'b0;
    end else begin : g_ctl_tk_port
        assign ctl_tk_valid = c_tk_valid;
        assign c_tk_ready   = ctl_tk_ready;
    end

    if (NT_SINK[CTL_IDX]) begin : g_ctl_nt_sink
        logic unused_ctl_nt_rdy;
        assign unused_ctl_nt_rdy = ctl_nt_ready;
        bbx_sink #(.DW(1)) u_sink (
            .in_valid (c_nt_valid),
            .in_data  (1'b0),
            .in_ready (c_nt_ready)
        );
        assign ctl_nt_valid = 1'b0;
    end else begin : g_ctl_nt_port
        assign ctl_nt_valid = c_nt_valid;
        assign c_nt_ready   = ctl_nt_ready;
    end

    assert_cond_taken_with_units_R6: assert property (@(posedge clk) disable iff (rst)
        (cond_valid && cond_ready) |-> (cp_valid == '0 || (cp_valid & cp_ready) == cp_valid));

endmodule

// File: tb/test_bbexit_steer.sv
`timescale 1ns/1ps
module test_bbexit_steer;

    localparam int N_LIVE = 2;
    localparam int DW     = 8;
    localparam logic [4:0] TK_SINK = 5'b00100;
    localparam logic [4:0] NT_SINK = 5'b00001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cond_valid = 1'b0, cond_value = 1'b0, cond_ready;
    logic [N_LIVE-1:0] lo_valid = '0, lo_ready;
    logic [N_LIVE*DW-1:0] lo_data = '0;
    logic ctl_valid = 1'b0, ctl_ready;
    logic [N_LIVE-1:0] tk_valid, nt_valid;
    logic [N_LIVE-1:0] tk_ready = '0, nt_ready = '0;
    logic [N_LIVE*DW-1:0] tk_data, nt_data;
    logic ctl_tk_valid, ctl_nt_valid;
    logic ctl_tk_ready = 1'b0, ctl_nt_ready = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    bbexit_steer #(.N_LIVE(N_LIVE), .DW(DW), .TK_SINK(TK_SINK), .NT_SINK(NT_SINK)) i_bbexit_steer (
        .clk(clk), .rst(rst),
        .cond_valid(cond_valid), .cond_value(cond_value), .cond_ready(cond_ready),
        .lo_valid(lo_valid), .lo_data(lo_data), .lo_ready(lo_ready),
        .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
        .tk_valid(tk_valid), .tk_data(tk_data), .tk_ready(tk_ready),
        .nt_valid(nt_valid), .nt_data(nt_data), .nt_ready(nt_ready),
        .ctl_tk_valid(ctl_tk_valid), .ctl_tk_ready(ctl_tk_ready),
        .ctl_nt_valid(ctl_nt_valid), .ctl_nt_ready(ctl_nt_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int data_of(input int rnd, input int i);
        return (rnd * 29 + i * 71 + 5) % 256;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic idle_inputs();
        cond_valid = 0; lo_valid = '0; ctl_valid = 0;
        tk_ready = '0; nt_ready = '0; ctl_tk_ready = 0; ctl_nt_ready = 0;
    endtask

    task automatic check_idle(input string tag);
        check(tk_valid == '0 && nt_valid == '0 && !ctl_tk_valid && !ctl_nt_valid,
              {tag, " R1 outputs idle"}, int'({tk_valid, nt_valid, ctl_tk_valid, ctl_nt_valid}), 0);
        check(!cond_ready && lo_ready == '0 && !ctl_ready,
              {tag, " R1 inputs not ready"}, int'({cond_ready, lo_ready, ctl_ready}), 0);
    endtask

    // Unit 0,1 are live-outs, unit 2 is the control token.
    task automatic run_round(input int rnd, input bit c, input int cd,
                             input int d0, input int d1, input int d2,
                             input int e0, input int e1, input int e2,
                             input int max_k, input bit do_check);
        int d[3], dd[3], acc[3], cnt_tk[3], cnt_nt[3], dat_ok[3];
        bit in_done[3];
        bit cond_done;
        int cond_cyc;
        bit f_both, f_early, f_sink, f_hold;
        d[0] = d0; d[1] = d1; d[2] = d2;
        dd[0] = e0; dd[1] = e1; dd[2] = e2;
        for (int i = 0; i < 3; i++) begin
            acc[i] = -1; cnt_tk[i] = 0; cnt_nt[i] = 0; dat_ok[i] = 1; in_done[i] = 0;
        end
        cond_done = 0; cond_cyc = -1;
        f_both = 0; f_early = 0; f_sink = 0; f_hold = 0;
        for (int i = 0; i < N_LIVE; i++) lo_data[i*DW +: DW] = DW'(data_of(rnd, i));
        cond_value = c;
        for (int k = 0; k < max_k; k++) begin
            @(negedge clk);
            cond_valid = (k >= cd) && !cond_done;
            for (int i = 0; i < N_LIVE; i++) begin
                lo_valid[i] = (k >= dd[i]) && !in_done[i];
                tk_ready[i] = (k >= d[i]);
                nt_ready[i] = (k >= d[i]);
            end
            ctl_valid    = (k >= dd[2]) && !in_done[2];
            ctl_tk_ready = (k >= d[2]);
            ctl_nt_ready = (k >= d[2]);
            #1;
            for (int i = 0; i < 3; i++) begin
                bit vt, vf, rt, rf, iv, ir, snk_t, snk_f;
                int dt, df;
                if (i < N_LIVE) begin
                    vt = tk_valid[i]; vf = nt_valid[i]; rt = tk_ready[i]; rf = nt_ready[i];
                    dt = int'(tk_data[i*DW +: DW]); df = int'(nt_data[i*DW +: DW]);
                    iv = lo_valid[i]; ir = lo_ready[i];
                end else begin
                    vt = ctl_tk_valid; vf = ctl_nt_valid; rt = ctl_tk_ready; rf = ctl_nt_ready;
                    dt = 0; df = 0; iv = ctl_valid; ir = ctl_ready;
                end
                snk_t = TK_SINK[i]; snk_f = NT_SINK[i];
                if (vt && vf) f_both = 1;
                if ((vt || vf) && (k < cd || k < dd[i])) f_early = 1;
                if ((snk_t && vt) || (snk_f && vf)) f_sink = 1;
                if (((vt && !rt) || (vf && !rf)) && ir) f_hold = 1;
                if (vt && rt) begin
                    cnt_tk[i]++;
                    if (i < N_LIVE && dt != data_of(rnd, i)) dat_ok[i] = 0;
                end
                if (vf && rf) begin
                    cnt_nt[i]++;
                    if (i < N_LIVE && df != data_of(rnd, i)) dat_ok[i] = 0;
                end
                if (iv && ir) begin in_done[i] = 1; acc[i] = k; end
            end
            if (cond_valid && cond_ready) begin cond_done = 1; cond_cyc = k; end
            @(posedge clk);
            if (cond_done && in_done[0] && in_done[1] && in_done[2]) break;
        end
        @(negedge clk);
        idle_inputs();
        if (do_check) begin
            int last;
            last = -1;
            for (int i = 0; i < 3; i++) begin
                bit snk;
                int exp_tk, exp_nt, exp_acc;
                snk = c ? TK_SINK[i] : NT_SINK[i];
                exp_tk = (c && !snk) ? 1 : 0;
                exp_nt = (!c && !snk) ? 1 : 0;
                exp_acc = imax(cd, imax(dd[i], snk ? 0 : d[i]));
                last = imax(last, exp_acc);
                if (i == 2) begin
                    check(cnt_tk[i] == exp_tk && cnt_nt[i] == exp_nt, "R8 control steering",
                          cnt_tk[i] * 10 + cnt_nt[i], exp_tk * 10 + exp_nt);
                end else if (c) begin
                    check(cnt_tk[i] == exp_tk && cnt_nt[i] == 0 && dat_ok[i] == 1, "R2 taken delivery",
                          cnt_tk[i] * 10 + cnt_nt[i], exp_tk * 10);
                end else begin
                    check(cnt_nt[i] == exp_nt && cnt_tk[i] == 0 && dat_ok[i] == 1, "R3 not-taken delivery",
                          cnt_tk[i] * 10 + cnt_nt[i], exp_nt);
                end
                check(acc[i] == exp_acc, "R6 unit accept cycle", acc[i], exp_acc);
            end
            check(cond_cyc == last, "R6 condition accept cycle", cond_cyc, last);
            check(!f_both, "R4 both sides valid", int'(f_both), 0);
            check(!f_early, "R5 output before both inputs", int'(f_early), 0);
            check(!f_sink, "R7 absorbed side raised valid", int'(f_sink), 0);
            check(!f_hold, "R9 input ready during stall", int'(f_hold), 0);
        end
    endtask

    initial begin
        int rnd;
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check_idle("after reset");
        rnd = 0;
        for (int c = 0; c < 2; c++)
            for (int cd = 0; cd <= 2; cd += 2)
                for (int late = 0; late < 2; late++)
                    for (int d0 = 0; d0 < 3; d0++)
                        for (int d1 = 0; d1 < 3; d1++)
                            for (int d2 = 0; d2 < 3; d2++) begin
                                run_round(rnd, c[0], cd, d0, d1, d2, 0, late ? 3 : 0, 0, 20, 1);
                                rnd++;
                            end
        // Mid-flight reset: units 0 and 2 served, unit 1 stalled.
        run_round(rnd, 1'b1, 0, 0, 6, 0, 0, 0, 0, 2, 0);
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check_idle("mid-flight reset");
        rnd++;
        run_round(rnd, 1'b1, 0, 0, 0, 0, 0, 0, 0, 20, 1);
        rnd++;
        run_round(rnd, 1'b0, 0, 1, 0, 2, 0, 0, 0, 20, 1);
        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule